// File: doc/BRIEF.md
# Time-Locked System Option Register

This block holds one byte of chip-level configuration for a small microcontroller and drives each field straight out to the logic that uses it. The fields are: analog converter power-up, clock source select, IRQ edge/level choice, oscillator start-up delay, clock-monitor enable and the two-bit watchdog rate. The CPU reaches the register through a simple byte bus with an address, a write strobe, write data and combinational read data.

Four of the fields are safety-relevant: the IRQ sense, the oscillator delay and both watchdog-rate bits. In normal mode these accept a single write, and only inside a fixed window of clock cycles after reset. The first write that lands in that window uses up the one chance, even if it writes the same value. In special mode the protection is lifted entirely. The remaining fields are always writable. A write that reaches locked bits still updates the free bits in the same byte.

Top module: `sysopt_reg`

## Requirements
- R1: While reset is asserted and after its release, the register holds 0x10. That value sets the oscillator-delay bit (bit 4) and clears every other bit.
- R2: A read at address REG_ADDR (default 0x39) returns the register with bit 2 forced to 0. A read at any other address returns 0x00.
- R3: Bits 7 (converter power-up), 6 (clock select) and 3 (clock-monitor enable) take the written value on every write to REG_ADDR, in either mode and at any time.
- R4: In normal mode (specialMode=0), bits 5, 4, 1 and 0 take a write that arrives on clock edges 0 through WINDOW-1 after reset release (default WINDOW=64), provided no earlier write has been made.
- R5: In normal mode, a write on edge WINDOW or later leaves bits 5, 4, 1 and 0 unchanged.
- R6: In normal mode, the first write inside the window locks bits 5, 4, 1 and 0, even when it writes the value they already hold. Later writes leave those bits unchanged.
- R7: In special mode (specialMode=1), bits 5, 4, 1 and 0 take every write, at any time and any number of times.
- R8: Bit 2 ignores writes and always reads 0.
- R9: A write whose protected part is rejected still updates bits 7, 6 and 3.
- R10: The outputs follow the stored fields: convPowerUp=bit 7, clkSelect=bit 6, irqEdgeMode=bit 5 (1 selects edge-only, 0 selects level), oscDelayEn=bit 4, clkMonEn=bit 3, wdRate=bits 1:0.
- R11: A write to any address other than REG_ADDR changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode, which removes the write-once protection |
| busAddr | input | 8 | Register-block address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational |
| convPowerUp | output | 1 | Analog converter power-up |
| clkSelect | output | 1 | Clock source select |
| irqEdgeMode | output | 1 | 1 = edge-only IRQ, 0 = level IRQ |
| oscDelayEn | output | 1 | Oscillator start-up delay enable |
| clkMonEn | output | 1 | Clock-monitor reset enable |
| wdRate | output | 2 | Watchdog rate select |

## Verification
Assertions check four things on every cycle. The window counter saturates and never exceeds its limit. No protected strobe is issued after the window closes, or after the single write has been used, in normal mode. Protected bits stay put when no protected strobe is issued. Free bits follow every addressed write. The bench scenarios cover what only whole sequences can show: the exact boundary between edge 63 and edge 64, an unchanged-data write consuming the single chance, unlimited rewrites in special mode, bit 2 reading zero after a write of one, and reads and writes at a foreign address.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] FREE_MASK  = 8'hC8;
  localparam logic [REG_W-1:0] PROT_MASK  = 8'h33;
  localparam logic [REG_W-1:0] RESET_VAL  = 8'h10;

  localparam int BIT_CONV  = 7;
  localparam int BIT_CSEL  = 6;
  localparam int BIT_IRQ   = 5;
  localparam int BIT_OSC   = 4;
  localparam int BIT_MON   = 3;

  typedef struct packed {
    logic wrFree;
    logic wrProt;
  } wrStrobe_t;
endpackage

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
  import sysopt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h39,
  parameter int WINDOW   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output logic              addrHit,
  output wrStrobe_t         stb
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cycleCnt;
  logic             windowOpen;
  logic             usedOnce;
  logic             wrHit;

  assign addrHit    = (busAddr == REG_ADDR);
  assign wrHit      = busWrEn && addrHit;
  assign windowOpen = (cycleCnt < WIN_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (windowOpen) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedOnce <= 1'b0;
    end else if (wrHit && !specialMode && windowOpen) begin
      usedOnce <= 1'b1;
    end
  end

  always_comb begin
    stb.wrFree = wrHit;
    stb.wrProt = wrHit && (specialMode || (windowOpen && !usedOnce));
  end

  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt <= WIN_C);
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleCnt == WIN_C) |=> (cycleCnt == WIN_C));
  p_window_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && (cycleCnt == WIN_C)) |-> !stb.wrProt);
  p_single_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && usedOnce) |-> !stb.wrProt);
  p_special_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode && busWrEn && addrHit) |-> stb.wrProt);
endmodule

// File: rtl/sysopt_dp.sv
module sysopt_dp
  import sysopt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regVal
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (FREE_MASK[i]) begin : g_free
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           regVal[i] <= RESET_VAL[i];
        else if (stb.wrFree) regVal[i] <= wrData[i];
      end
    end else if (PROT_MASK[i]) begin : g_prot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           regVal[i] <= RESET_VAL[i];
        else if (stb.wrProt) regVal[i] <= wrData[i];
      end
    end else begin : g_none
      assign regVal[i] = 1'b0;
    end
  end

  p_prot_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrProt |=> $stable(regVal & PROT_MASK));
  p_free_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrFree |=> ((regVal & FREE_MASK) == ($past(wrData) & FREE_MASK)));
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h39,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              convPowerUp,
  output logic              clkSelect,
  output logic              irqEdgeMode,
  output logic              oscDelayEn,
  output logic              clkMonEn,
  output logic [1:0]        wdRate
);
  import sysopt_pkg::*;

  wrStrobe_t        stb;
  logic             addrHit;
  logic [REG_W-1:0] regVal;

  sysopt_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .addrHit(addrHit), .stb(stb)
  );

  sysopt_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .regVal(regVal)
  );

  assign busRdData   = addrHit ? regVal : '0;
  assign convPowerUp = regVal[BIT_CONV];
  assign clkSelect   = regVal[BIT_CSEL];
  assign irqEdgeMode = regVal[BIT_IRQ];
  assign oscDelayEn  = regVal[BIT_OSC];
  assign clkMonEn    = regVal[BIT_MON];
  assign wdRate      = regVal[1:0];

  p_foreign_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr != REG_ADDR)) |=> $stable(regVal));
endmodule

// File: tb/tb_sysopt_reg.sv
module tb_sysopt_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       convPowerUp, clkSelect, irqEdgeMode, oscDelayEn, clkMonEn;
  logic [1:0] wdRate;

  int errors = 0;
  int checks = 0;

  localparam logic [7:0] ADDR = 8'h39;

  always #5 clk = ~clk;

  sysopt_reg dut (
    .clk(clk), .rstN(rstN), .specialMode(specialMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .convPowerUp(convPowerUp), .clkSelect(clkSelect),
    .irqEdgeMode(irqEdgeMode), .oscDelayEn(oscDelayEn), .clkMonEn(clkMonEn),
    .wdRate(wdRate)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic spec);
    @(negedge clk);
    specialMode = spec;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = ADDR;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
    busAddr = ADDR;
  endtask

  task automatic testReset();
    logic [7:0] v;
    doReset(1'b0);
    readReg(ADDR, v);
    check("R1 reset value", v, 8'h10);
    check("R10 outputs at reset",
          {convPowerUp, clkSelect, irqEdgeMode, oscDelayEn, clkMonEn, 1'b0, wdRate}, 8'h10);
  endtask

  task automatic testInWindow();
    logic [7:0] v;
    doReset(1'b0);
    idle(5);
    writeReg(ADDR, 8'hFF);
    readReg(ADDR, v);
    check("R4 R8 write in window", v, 8'hFB);
    check("R10 outputs after write",
          {convPowerUp, clkSelect, irqEdgeMode, oscDelayEn, clkMonEn, 1'b0, wdRate}, 8'hFB);
    writeReg(ADDR, 8'h00);
    readReg(ADDR, v);
    check("R6 R9 second write locked, free bits cleared", v, 8'h33);
  endtask

  task automatic testSameData();
    logic [7:0] v;
    doReset(1'b0);
    writeReg(ADDR, 8'h10);
    writeReg(ADDR, 8'h23);
    readReg(ADDR, v);
    check("R6 unchanged-data write consumes chance", v, 8'h10);
  endtask

  task automatic testEdge63();
    logic [7:0] v;
    doReset(1'b0);
    idle(63);
    writeReg(ADDR, 8'h21);
    readReg(ADDR, v);
    check("R4 write on last window edge", v, 8'h21);
  endtask

  task automatic testEdge64();
    logic [7:0] v;
    doReset(1'b0);
    idle(64);
    writeReg(ADDR, 8'h21);
    readReg(ADDR, v);
    check("R5 write after window rejected", v, 8'h10);
    writeReg(ADDR, 8'h8B);
    readReg(ADDR, v);
    check("R9 R3 free bits take locked write", v, 8'h98);
  endtask

  task automatic testSpecial();
    logic [7:0] v;
    doReset(1'b1);
    idle(100);
    writeReg(ADDR, 8'h33);
    readReg(ADDR, v);
    check("R7 special late write", v, 8'h33);
    writeReg(ADDR, 8'h00);
    readReg(ADDR, v);
    check("R7 special second write", v, 8'h00);
    writeReg(ADDR, 8'h13);
    readReg(ADDR, v);
    check("R7 special third write", v, 8'h13);
    writeReg(ADDR, 8'h04);
    readReg(ADDR, v);
    check("R8 bit 2 ignores writes", v, 8'h00);
  endtask

  task automatic testForeign();
    logic [7:0] v;
    doReset(1'b1);
    writeReg(8'h38, 8'hFF);
    readReg(ADDR, v);
    check("R11 foreign write no effect", v, 8'h10);
    readReg(8'h38, v);
    check("R2 foreign read returns zero", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    busAddr = ADDR;
    testReset();
    testInWindow();
    testSameData();
    testEdge63();
    testEdge64();
    testSpecial();
    testForeign();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule